// File: doc/BRIEF.md
# Commutation-Gated Control Shadow Register

This block keeps the per-channel output control of a PWM timer: a channel enable, a complementary-output enable and an output-mode field for each channel. Software writes these through a narrow port that addresses one channel at a time. A preload setting selects when a write reaches the active copy that drives the output stage. With preload off, a write takes effect on the next clock. With preload on, channels that have a complementary output hold the write in a shadow copy. The shadow moves to the active copy only when a commutation event occurs.

A commutation event comes from a software strobe. It can also come from a rising edge on a trigger input when the trigger source is enabled. Each event sets a sticky flag, and software clears the flag by writing 0. Channels without a complementary output never use the shadow and always update directly. A separate request line per channel is driven from one of two sources, chosen by a selection bit: that channel's capture/compare event or the shared update event.

Top module: `comgate_ctl`

## Requirements
- R1: Synchronous reset clears the active and shadow controls of every channel, the preload, trigger-source and request-source settings, the sticky flag and the request lines.
- R2: With preload off, a write addressed by `ch_sel` sets that channel's `act_en`, `act_cen` and its `MODE_W`-bit slice of `act_mode` (bits `[i*MODE_W +: MODE_W]` for channel i) on the clock after the write.
- R3: With preload on, a write to a channel with a complementary output leaves its active controls unchanged until a commutation event, which then copies the shadow to the active controls on the following clock.
- R4: With the trigger source off, only `com_sw` causes a commutation; edges on `trig_in` have no effect on the active controls or on the flag.
- R5: With the trigger source on, a 0-to-1 change of `trig_in` between consecutive clocks also causes a commutation, and a level that stays high causes no further commutation.
- R6: Channels whose bit in `CH_HAS_COMP` is 0 take every write on the next clock, whatever the preload setting, and ignore commutation events.
- R7: A write and a commutation in the same clock put the newly written value into the active controls.
- R8: Each commutation sets `com_flag`. Writing `flag_wdata`=0 with `flag_we` clears it. Writing 1 has no effect. A commutation in the same clock as a clear leaves the flag set.
- R9: With request-source 0, `dma_req[i]` follows `cc_evt[i]` one clock later. With request-source 1, every bit of `dma_req` follows `upd_evt` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the three setting bits below |
| cfg_preload | input | 1 | Preload setting (1 = hold writes in shadow) |
| cfg_trig_sel | input | 1 | Trigger source setting (1 = trigger edge also commutes) |
| cfg_dma_sel | input | 1 | Request source (0 = capture/compare, 1 = update) |
| ch_we | input | 1 | Channel control write strobe |
| ch_sel | input | CH_IDX_W | Channel index of the write |
| ch_en | input | 1 | Written channel enable |
| ch_cen | input | 1 | Written complementary enable |
| ch_mode | input | MODE_W | Written output mode |
| com_sw | input | 1 | Software commutation strobe |
| trig_in | input | 1 | Trigger input |
| upd_evt | input | 1 | Update event pulse |
| cc_evt | input | NUM_CH | Per-channel capture/compare event pulses |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write value (0 clears) |
| act_en | output | NUM_CH | Active channel enables |
| act_cen | output | NUM_CH | Active complementary enables |
| act_mode | output | NUM_CH*MODE_W | Active output modes, packed per channel |
| com_flag | output | 1 | Sticky commutation flag |
| dma_req | output | NUM_CH | Per-channel request lines |

## Verification
Every result is due one clock after the edge that samples its cause. A write, a commutation, a flag write and an event on the request sources all show at the outputs one cycle later. A setting change first takes effect on the stimulus of the following cycle. The bench drives inputs on the falling edge and compares every output against a behavioural model on each falling edge, so each result is checked exactly in its due cycle. Directed checks are placed right after the rising edge that should produce a change. Held-level and no-effect cases are then checked again over later cycles to confirm that nothing moves.

// File: rtl/comgate_pkg.sv
package comgate_pkg;
  typedef struct packed {
    logic preload;
    logic trig_sel;
    logic dma_sel;
  } comgate_cfg_t;
endpackage

// File: rtl/comgate_com_gen.sv
module comgate_com_gen (
  input  logic clk,
  input  logic rst,
  input  logic sw_strobe,
  input  logic trig_in,
  input  logic trig_sel,
  output logic com_evt
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_in;
  end

  assign com_evt = sw_strobe | (trig_sel & trig_in & ~trig_q);

  // R4
  sel_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!trig_sel && !sw_strobe) |-> !com_evt);

  // R5
  trig_held_once_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && trig_in && $past(trig_in) && !sw_strobe) |-> !com_evt);

  // R5
  trig_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && trig_sel && trig_in && !$past(trig_in)) |-> com_evt);
endmodule

// File: rtl/comgate_chan.sv
module comgate_chan #(
  parameter int MODE_W   = 3,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preload,
  input  logic              com_evt,
  input  logic              wr_hit,
  input  logic              wr_en,
  input  logic              wr_cen,
  input  logic [MODE_W-1:0] wr_mode,
  output logic              act_en,
  output logic              act_cen,
  output logic [MODE_W-1:0] act_mode
);
  generate
    if (HAS_COMP) begin : g_comp
      logic              sh_en, sh_cen;
      logic [MODE_W-1:0] sh_mode;
      logic              nx_en, nx_cen;
      logic [MODE_W-1:0] nx_mode;

      always_comb begin
        nx_en   = wr_hit ? wr_en   : sh_en;
        nx_cen  = wr_hit ? wr_cen  : sh_cen;
        nx_mode = wr_hit ? wr_mode : sh_mode;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          sh_en    <= 1'b0;
          sh_cen   <= 1'b0;
          sh_mode  <= '0;
          act_en   <= 1'b0;
          act_cen  <= 1'b0;
          act_mode <= '0;
        end else begin
          sh_en   <= nx_en;
          sh_cen  <= nx_cen;
          sh_mode <= nx_mode;
          if (com_evt) begin
            act_en   <= nx_en;
            act_cen  <= nx_cen;
            act_mode <= nx_mode;
          end else if (wr_hit && !preload) begin
            act_en   <= wr_en;
            act_cen  <= wr_cen;
            act_mode <= wr_mode;
          end
        end
      end

      // R3
      preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (preload && !com_evt) |=> $stable({act_en, act_cen, act_mode}));

      // R7
      write_com_same_chk: assert property (@(posedge clk) disable iff (rst)
        (com_evt && wr_hit) |=> ({act_en, act_cen, act_mode} == $past({wr_en, wr_cen, wr_mode})));
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          act_en   <= 1'b0;
          act_cen  <= 1'b0;
          act_mode <= '0;
        end else if (wr_hit) begin
          act_en   <= wr_en;
          act_cen  <= wr_cen;
          act_mode <= wr_mode;
        end
      end

      // R6
      direct_ignores_com_chk: assert property (@(posedge clk) disable iff (rst)
        (com_evt && !wr_hit) |=> $stable({act_en, act_cen, act_mode}));
    end
  endgenerate

  // R2
  direct_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && (!preload || !HAS_COMP)) |=> ({act_en, act_cen, act_mode} == $past({wr_en, wr_cen, wr_mode})));
endmodule

// File: rtl/comgate_dma_sel.sv
module comgate_dma_sel #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_sel,
  input  logic              upd_evt,
  input  logic [NUM_CH-1:0] cc_evt,
  output logic [NUM_CH-1:0] dma_req
);
  always_ff @(posedge clk) begin
    if (rst)          dma_req <= '0;
    else if (dma_sel) dma_req <= {NUM_CH{upd_evt}};
    else              dma_req <= cc_evt;
  end

  // R9
  req_from_update_chk: assert property (@(posedge clk) disable iff (rst)
    dma_sel |=> (dma_req == {NUM_CH{$past(upd_evt)}}));

  // R9
  req_from_cc_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_sel |=> (dma_req == $past(cc_evt)));
endmodule

// File: rtl/comgate_ctl.sv
module comgate_ctl #(
  parameter int                NUM_CH      = 4,
  parameter int                MODE_W      = 3,
  parameter logic [NUM_CH-1:0] CH_HAS_COMP = 'h3,
  localparam int               CH_IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_preload,
  input  logic                     cfg_trig_sel,
  input  logic                     cfg_dma_sel,
  input  logic                     ch_we,
  input  logic [CH_IDX_W-1:0]      ch_sel,
  input  logic                     ch_en,
  input  logic                     ch_cen,
  input  logic [MODE_W-1:0]        ch_mode,
  input  logic                     com_sw,
  input  logic                     trig_in,
  input  logic                     upd_evt,
  input  logic [NUM_CH-1:0]        cc_evt,
  input  logic                     flag_we,
  input  logic                     flag_wdata,
  output logic [NUM_CH-1:0]        act_en,
  output logic [NUM_CH-1:0]        act_cen,
  output logic [NUM_CH*MODE_W-1:0] act_mode,
  output logic                     com_flag
  ,
  output logic [NUM_CH-1:0]        dma_req
);
  import comgate_pkg::*;

  comgate_cfg_t      cfg_q;
  logic              com_evt;
  logic [NUM_CH-1:0] wr_hit;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= '{preload: cfg_preload, trig_sel: cfg_trig_sel, dma_sel: cfg_dma_sel};
  end

  comgate_com_gen u_com_gen (
    .clk       (clk),
    .rst       (rst),
    .sw_strobe (com_sw),
    .trig_in   (trig_in),
    .trig_sel  (cfg_q.trig_sel),
    .com_evt   (com_evt)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign wr_hit[i] = ch_we && (ch_sel == CH_IDX_W'(i));

      comgate_chan #(
        .MODE_W   (MODE_W),
        .HAS_COMP (CH_HAS_COMP[i])
      ) u_chan (
        .clk      (clk),
        .rst      (rst),
        .preload  (cfg_q.preload),
        .com_evt  (com_evt),
        .wr_hit   (wr_hit[i]),
        .wr_en    (ch_en),
        .wr_cen   (ch_cen),
        .wr_mode  (ch_mode),
        .act_en   (act_en[i]),
        .act_cen  (act_cen[i]),
        .act_mode (act_mode[i*MODE_W +: MODE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                       com_flag <= 1'b0;
    else if (com_evt)              com_flag <= 1'b1;
    else if (flag_we && !flag_wdata) com_flag <= 1'b0;
  end

  comgate_dma_sel #(.NUM_CH(NUM_CH)) u_dma_sel (
    .clk     (clk),
    .rst     (rst),
    .dma_sel (cfg_q.dma_sel),
    .upd_evt (upd_evt),
    .cc_evt  (cc_evt),
    .dma_req (dma_req)
  );

  // R8
  flag_set_by_com_chk: assert property (@(posedge clk) disable iff (rst)
    com_evt |=> com_flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !flag_wdata && !com_evt) |=> !com_flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (com_flag && !(flag_we && !flag_wdata)) |=> com_flag);
endmodule

// File: tb/comgate_ctl_bench.sv
`timescale 1ns/1ps
module comgate_ctl_bench;
  localparam int N  = 4;
  localparam int MW = 3;
  localparam int IW = 2;
  localparam logic [N-1:0] COMP = 4'b0011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_preload = 0, cfg_trig_sel = 0, cfg_dma_sel = 0;
  logic ch_we = 0, ch_en = 0, ch_cen = 0;
  logic [IW-1:0] ch_sel = '0;
  logic [MW-1:0] ch_mode = '0;
  logic com_sw = 0, trig_in = 0, upd_evt = 0, flag_we = 0, flag_wdata = 0;
  logic [N-1:0] cc_evt = '0;
  logic [N-1:0] act_en, act_cen, dma_req;
  logic [N*MW-1:0] act_mode;
  logic com_flag;

  always #4 clk = ~clk;

  comgate_ctl #(.NUM_CH(N), .MODE_W(MW), .CH_HAS_COMP(COMP)) u_comgate_ctl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_preload(cfg_preload),
    .cfg_trig_sel(cfg_trig_sel), .cfg_dma_sel(cfg_dma_sel), .ch_we(ch_we),
    .ch_sel(ch_sel), .ch_en(ch_en), .ch_cen(ch_cen), .ch_mode(ch_mode),
    .com_sw(com_sw), .trig_in(trig_in), .upd_evt(upd_evt), .cc_evt(cc_evt),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .act_en(act_en),
    .act_cen(act_cen), .act_mode(act_mode), .com_flag(com_flag), .dma_req(dma_req)
  );

  int vectors = 0;
  int miscomp = 0;
  bit cmp_on = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit m_en[N], m_cen[N], s_en[N], s_cen[N];
  int m_mode[N], s_mode[N];
  bit m_pre, m_sel, m_dsel, m_tq, m_flag;
  logic [N-1:0] m_dma;

  always @(posedge clk) begin
    bit com;
    bit hit;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_en[i] = 0; m_cen[i] = 0; m_mode[i] = 0;
        s_en[i] = 0; s_cen[i] = 0; s_mode[i] = 0;
      end
      m_pre = 0; m_sel = 0; m_dsel = 0; m_tq = 0; m_flag = 0; m_dma = '0;
    end else begin
      com = com_sw || (m_sel && trig_in && !m_tq);
      for (int i = 0; i < N; i++) begin
        hit = ch_we && (int'(ch_sel) == i);
        if (COMP[i]) begin
          if (hit) begin s_en[i] = ch_en; s_cen[i] = ch_cen; s_mode[i] = int'(ch_mode); end
          if (com) begin
            m_en[i] = s_en[i]; m_cen[i] = s_cen[i]; m_mode[i] = s_mode[i];
          end else if (hit && !m_pre) begin
            m_en[i] = ch_en; m_cen[i] = ch_cen; m_mode[i] = int'(ch_mode);
          end
        end else if (hit) begin
          m_en[i] = ch_en; m_cen[i] = ch_cen; m_mode[i] = int'(ch_mode);
        end
      end
      if (com) m_flag = 1;
      else if (flag_we && !flag_wdata) m_flag = 0;
      m_dma = m_dsel ? {N{upd_evt}} : cc_evt;
      if (cfg_we) begin m_pre = cfg_preload; m_sel = cfg_trig_sel; m_dsel = cfg_dma_sel; end
      m_tq = trig_in;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [N-1:0] e_en, e_cen;
    logic [N*MW-1:0] e_mode;
    if (cmp_on && !done) begin
      for (int i = 0; i < N; i++) begin
        e_en[i] = m_en[i];
        e_cen[i] = m_cen[i];
        e_mode[i*MW +: MW] = MW'(m_mode[i]);
      end
      check(cur_req, "model act_en", 32'(act_en), 32'(e_en));
      check(cur_req, "model act_cen", 32'(act_cen), 32'(e_cen));
      check(cur_req, "model act_mode", 32'(act_mode), 32'(e_mode));
      check(cur_req, "model com_flag", 32'(com_flag), 32'(m_flag));
      check(cur_req, "model dma_req", 32'(dma_req), 32'(m_dma));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_cfg(logic pre, logic sel, logic dsel);
    cfg_we = 1; cfg_preload = pre; cfg_trig_sel = sel; cfg_dma_sel = dsel;
    tick();
    cfg_we = 0;
  endtask

  task automatic wr_ch(int ch, logic en, logic cen, int mode, logic with_com);
    ch_we = 1; ch_sel = IW'(ch); ch_en = en; ch_cen = cen; ch_mode = MW'(mode); com_sw = with_com;
    tick();
    ch_we = 0; com_sw = 0;
  endtask

  task automatic wr_flag(logic v, logic with_com);
    flag_we = 1; flag_wdata = v; com_sw = with_com;
    tick();
    flag_we = 0; com_sw = 0;
  endtask

  function automatic logic [31:0] mode_of(int ch);
    return 32'(act_mode[ch*MW +: MW]);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    miscomp++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    tick();
    cmp_on = 1;
    tick(); tick();
    cur_req = "R1";
    check("R1", "act_en after reset", 32'(act_en), 0);
    check("R1", "com_flag after reset", 32'(com_flag), 0);
    check("R1", "dma_req after reset", 32'(dma_req), 0);
    rst = 0;

    cur_req = "R2";
    wr_ch(0, 1, 1, 3, 0);
    check("R2", "ch0 en", 32'(act_en[0]), 1);
    check("R2", "ch0 cen", 32'(act_cen[0]), 1);
    check("R2", "ch0 mode", mode_of(0), 3);

    cur_req = "R3";
    set_cfg(1, 0, 0);
    wr_ch(0, 0, 1, 6, 0);
    check("R3", "ch0 en held", 32'(act_en[0]), 1);
    tick(); tick();
    check("R3", "ch0 mode held", mode_of(0), 3);
    com_sw = 1; tick(); com_sw = 0;
    check("R3", "ch0 en after com", 32'(act_en[0]), 0);
    check("R3", "ch0 mode after com", mode_of(0), 6);
    check("R8", "flag after com", 32'(com_flag), 1);

    cur_req = "R6";
    wr_ch(2, 1, 0, 5, 0);
    check("R6", "ch2 en direct under preload", 32'(act_en[2]), 1);
    check("R6", "ch2 mode direct under preload", mode_of(2), 5);
    com_sw = 1; tick(); com_sw = 0;
    check("R6", "ch2 mode after com", mode_of(2), 5);

    cur_req = "R8";
    wr_flag(0, 0);
    check("R8", "flag cleared", 32'(com_flag), 0);
    wr_flag(1, 0);
    check("R8", "flag write 1 ignored", 32'(com_flag), 0);

    cur_req = "R4";
    wr_ch(1, 1, 0, 2, 0);
    trig_in = 1; tick(); tick();
    check("R4", "ch1 en with trigger off", 32'(act_en[1]), 0);
    check("R4", "flag with trigger off", 32'(com_flag), 0);
    trig_in = 0; tick();

    cur_req = "R5";
    set_cfg(1, 1, 0);
    trig_in = 1; tick();
    check("R5", "ch1 en on trigger edge", 32'(act_en[1]), 1);
    check("R5", "ch1 mode on trigger edge", mode_of(1), 2);
    wr_ch(1, 0, 1, 7, 0);
    tick(); tick();
    check("R5", "ch1 en with level held", 32'(act_en[1]), 1);
    wr_flag(0, 0);
    tick();
    check("R5", "flag with level held", 32'(com_flag), 0);
    trig_in = 0; tick();
    trig_in = 1; tick();
    check("R5", "ch1 en second edge", 32'(act_en[1]), 0);
    check("R5", "ch1 mode second edge", mode_of(1), 7);
    trig_in = 0; tick();

    cur_req = "R7";
    wr_ch(0, 1, 0, 1, 1);
    check("R7", "ch0 en write with com", 32'(act_en[0]), 1);
    check("R7", "ch0 cen write with com", 32'(act_cen[0]), 0);
    check("R7", "ch0 mode write with com", mode_of(0), 1);

    cur_req = "R8";
    wr_flag(0, 0);
    wr_flag(0, 1);
    check("R8", "com wins over clear", 32'(com_flag), 1);

    cur_req = "R9";
    set_cfg(1, 1, 0);
    cc_evt = 4'b1010; upd_evt = 1; tick();
    check("R9", "req from cc", 32'(dma_req), 32'h0000000a);
    set_cfg(1, 1, 1);
    cc_evt = 4'b1010; upd_evt = 0; tick();
    check("R9", "req ignores cc", 32'(dma_req), 0);
    cc_evt = 4'b0000; upd_evt = 1; tick();
    check("R9", "req from update", 32'(dma_req), 32'h0000000f);
    upd_evt = 0; tick();

    cur_req = "R1";
    rst = 1; tick();
    check("R1", "act_en after late reset", 32'(act_en), 0);
    check("R1", "act_mode after late reset", 32'(act_mode), 0);
    check("R1", "flag after late reset", 32'(com_flag), 0);
    rst = 0;
    com_sw = 1; tick(); com_sw = 0;
    check("R1", "shadow cleared by reset", 32'(act_en), 0);
    tick();
    finish_run();
  end
endmodule